// File: doc/BRIEF.md
# Manchester Line Encoder with Selectable Idle Style

This block turns serial NRZ transmit data from a MAC-side controller into Manchester-coded line data for a transceiver. It runs from a 20 MHz reference clock and halves it to make the 10 MHz transmit clock. That clock is exported so the controller can present its enable and data against it. Each bit cell spans two reference periods, and the outputs change only on reference-clock edges.

The line is a pair of logic-level outputs that stand for a differential pair. Every frame closes with a rising transition on the true output, and the line then stays high for a short tail before going idle. One select input picks the idle style:
- a held positive differential, for legacy Ethernet;
- zero differential, for 802.3 transformer-coupled links.

A loopback input silences the line pair. In every mode a single-ended copy of the encoded stream is offered for the receive path.

Top module: `manchester_tx_encoder`

## Requirements
- R1: `tx_clk` is the reference clock divided by two. It is low during reset, rises on the first reference edge after reset is released, and then toggles on every reference edge. Its rising edges are the sampling points for `tx_en` and `tx_data`.
- R2: When `tx_en` is sampled high on a rising `tx_clk` edge, a bit cell starts on that same edge and carries the `tx_data` sampled there. Consecutive high samples give back-to-back cells.
- R3: During a cell, `line_n` is the complement of `line_p`.
  - A one drives `line_p` low for the first reference period and high for the second.
  - A zero drives `line_p` high for the first reference period and low for the second.
- R4: When `tx_en` is first sampled low after a cell, `line_p` is high from that edge onward. This gives a rising end transition at the end of the cell after a final zero; after a final one, the line stays high from the mid-cell rise.
- R5: After the final cell, `line_p`=1 and `line_n`=0 for TAIL_CYC reference periods (default 4, i.e. 200 ns), unless a new cell starts earlier. After that the line enters idle.
- R6: Idle with `idle_zero`=0 (half-step) drives `line_p`=1 and `line_n`=0.
- R7: Idle with `idle_zero`=1 drives `line_p`=0 and `line_n`=0 (zero differential).
- R8: While `loop_en`=1, `line_p` and `line_n` are both 0. In every mode, `loop_data` equals the encoded level (the value `line_p` takes while sending) during cells and the tail, and is 1 in idle.
- R9: `tx_data` has no effect on any output while `tx_en` is sampled low.
- R10: During reset the outputs are idle: `tx_clk`=0, `loop_data`=1, `line_n`=0, and `line_p` set by the idle style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 20 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame enable from the controller, sampled on rising `tx_clk` |
| tx_data | input | 1 | NRZ data from the controller, sampled on rising `tx_clk` |
| idle_zero | input | 1 | Idle style: 0 = held positive differential, 1 = zero differential |
| loop_en | input | 1 | Loopback: line pair silenced, stream only on `loop_data` |
| tx_clk | output | 1 | 10 MHz transmit clock to the controller |
| line_p | output | 1 | True side of the line pair |
| line_n | output | 1 | Complement side of the line pair |
| loop_data | output | 1 | Single-ended encoded stream for the receive path |

## Verification
The embedded assertions check these properties on every cycle:
- the clock divider keeps toggling;
- every cell in flight has its mid-cell transition;
- the frame end lands high;
- the tail holds the line high and cannot overlap an active cell;
- the half-step idle level is correct.

Some behaviours can only be shown by the bench scenarios, which compare each output against waveforms built from the bit lists:
- that each cell's polarity matches the sampled data;
- the exact tail length and its truncation when a new frame follows within a short gap;
- the zero-differential idle;
- the loopback path;
- the insensitivity to `tx_data` while enable is low.

// File: rtl/manchester_tx_encoder.sv
module manchester_tx_encoder #(
  parameter int unsigned TAIL_CYC = 4
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_data,
  input  logic idle_zero,
  input  logic loop_en,
  output logic tx_clk,
  output logic line_p,
  output logic line_n,
  output logic loop_data
);
  localparam int unsigned TW = $clog2(TAIL_CYC + 1);

  logic          ph;
  logic          act;
  logic          bit_q;
  logic          enc;
  logic [TW-1:0] tail;
  logic          idle;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      act   <= 1'b0;
      bit_q <= 1'b0;
      enc   <= 1'b1;
      tail  <= '0;
    end else begin
      ph <= ~ph;
      if (!ph && tx_en) begin
        act   <= 1'b1;
        bit_q <= tx_data;
        enc   <= ~tx_data;
        tail  <= '0;
      end else if (!ph && act) begin
        act  <= 1'b0;
        enc  <= 1'b1;
        tail <= TW'(TAIL_CYC);
      end else begin
        if (act) enc <= bit_q;
        if (tail != '0) tail <= tail - 1'b1;
      end
    end
  end

  assign idle      = !act && (tail == '0);
  assign tx_clk    = ph;
  assign loop_data = enc;
  assign line_p    = !loop_en && (idle ? !idle_zero : enc);
  assign line_n    = !loop_en && !idle && !enc;

  // R1
  clk_toggle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    1'b1 |=> (tx_clk != $past(tx_clk)));

  // R3
  mid_transition_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (act && ph) |=> (loop_data != $past(loop_data)));

  // R4
  end_high_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(act) |-> loop_data);

  // R5
  tail_high_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (tail != '0) |-> (!act && loop_data));

  // R6
  half_step_idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (idle && !loop_en && !idle_zero) |-> (line_p && !line_n));
endmodule

// File: tb/test_manchester_tx_encoder.sv
`timescale 1ns/1ps
module test_manchester_tx_encoder;
  localparam int CLK_PERIOD = 50;
  localparam int TAIL = 4;

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, tx_data = 1'b0, idle_zero = 1'b0, loop_en = 1'b0;
  logic tx_clk, line_p, line_n, loop_data;

  int checks = 0, failures = 0;
  int since_end = 1000;
  logic exp_clk = 1'b0;
  bit done = 0;

  manchester_tx_encoder #(.TAIL_CYC(TAIL)) i_manchester_tx_encoder (
    .clk_ref, .rst_n, .tx_en, .tx_data, .idle_zero, .loop_en,
    .tx_clk, .line_p, .line_n, .loop_data);

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  function automatic logic [3:0] expect_out(logic ck, bit busy, logic e, logic zmode, logic lb);
    logic p, n, ld;
    ld = busy ? e : 1'b1;
    if (lb) begin p = 1'b0; n = 1'b0; end
    else if (busy) begin p = e; n = ~e; end
    else begin p = ~zmode; n = 1'b0; end
    return {ck, p, n, ld};
  endfunction

  task automatic check(string req, logic [3:0] actual, logic [3:0] expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s: {tx_clk,line_p,line_n,loop_data} actual=%b expected=%b at %0t",
               req, actual, expected, $time);
    end
  endtask

  task automatic step(string req, bit busy, logic e);
    @(negedge clk_ref);
    exp_clk = ~exp_clk;
    check(req, {tx_clk, line_p, line_n, loop_data},
          expect_out(exp_clk, busy, e, idle_zero, loop_en));
  endtask

  task automatic idle_cells(int n);
    for (int k = 0; k < 2*n; k++) begin
      string req;
      since_end++;
      if (since_end == 1) req = "R4";
      else if (since_end <= TAIL) req = "R5";
      else req = loop_en ? "R8" : (idle_zero ? "R7" : "R6");
      if (since_end > TAIL) req = {req, " R9"};
      step(req, since_end <= TAIL, 1'b1);
      if (!tx_clk) tx_data = 1'($urandom);
    end
  endtask

  task automatic run_frame(int len, logic [63:0] bits, int gap);
    tx_en = 1'b1;
    tx_data = bits[0];
    for (int i = 0; i < len; i++) begin
      step(loop_en ? "R8" : (i == 0 ? "R2" : "R3"), 1, ~bits[i]);
      step(loop_en ? "R8" : "R3", 1, bits[i]);
      if (i < len - 1) tx_data = bits[i+1];
      else begin tx_en = 1'b0; tx_data = 1'($urandom); end
    end
    since_end = 0;
    idle_cells(gap);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #(CLK_PERIOD*2 + 3);
    check("R10", {tx_clk, line_p, line_n, loop_data}, 4'b0101);
    idle_zero = 1'b1; #1;
    check("R10", {tx_clk, line_p, line_n, loop_data}, 4'b0001);
    idle_zero = 1'b0;
    @(negedge clk_ref);
    rst_n = 1'b1;
    idle_cells(3);
    step("R1", 0, 1'b1);
    step("R1", 0, 1'b1);

    run_frame(8, 64'hFF, 4);
    run_frame(8, 64'h00, 4);
    run_frame(1, 64'h1, 3);
    run_frame(1, 64'h0, 3);
    idle_zero = 1'b1;
    run_frame(6, 64'h2D, 1);
    run_frame(5, 64'h13, 4);
    run_frame(1, 64'h0, 4);
    loop_en = 1'b1;
    run_frame(7, 64'h5A, 4);
    idle_zero = 1'b0;
    run_frame(3, 64'h4, 3);
    loop_en = 1'b0;

    for (int f = 0; f < 80; f++) begin
      int len;
      int gap;
      logic [63:0] bits;
      len = 1 + int'($urandom_range(0, 31));
      gap = 1 + int'($urandom_range(0, 4));
      bits = {$urandom, $urandom};
      idle_zero = 1'($urandom);
      loop_en = ($urandom_range(0, 3) == 0);
      run_frame(len, bits, gap);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule